// File: doc/BRIEF.md
# Sliced GF(16) Arithmetic Unit

This block applies one arithmetic operation of the field GF(2^4) to a wide data word. The word is split into independent 4-bit lanes. Every lane holds one field element, a value from 0 to 15, and all lanes are reduced by the polynomial x^4 + x + 1 (binary 10011). One 2-bit opcode, shared by all lanes, selects addition, multiplication, doubling or a pass-through of the first operand. A caller places two operand words on the inputs and raises the strobe for one cycle. One cycle later, the result word appears together with its own valid flag.

Each lane multiplies through a 256-entry product table. The table is computed at elaboration by a shift-and-XOR reduction function, so no memory file is needed. A parameter can replace the table with the equivalent combinational network. The word width is a parameter and must be a multiple of four.

Top module: `gf16_lane_alu`

## Requirements
- R1: While reset is asserted and after its release, `res_valid` is 0 and `res` is all zeros until the first accepted operation.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, so latency is one cycle.
- R3: Opcode 00 (add) gives, in every lane, the bitwise XOR of the two 4-bit operand values.
- R4: Opcode 01 (multiply) gives the carry-less product of the two lane values reduced modulo 10011; for example, 8 times 7 gives 13.
- R5: Opcode 10 (double) adds the first operand to itself in the field, which gives 0 in every lane whatever the operands are.
- R6: Opcode 11 (pass) copies the first operand word to the result unchanged.
- R7: Lane i occupies bits 4i+3 down to 4i of both operands and of the result, and no lane's value affects another lane.
- R8: While `in_valid` is low, `res` keeps the last result.
- R9: A lane product with a zero operand is 0, and a lane product with an operand of 1 equals the other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 2 | 00 add, 01 multiply, 10 double, 11 pass |
| opa | input | DATA_W (256) | First operand word, 4-bit lanes |
| opb | input | DATA_W (256) | Second operand word, 4-bit lanes |
| res_valid | output | 1 | Result word is new this cycle |
| res | output | DATA_W (256) | Result word, 4-bit lanes |

## Verification
When strobes arrive back to back, the unit captures a new word on the same clock edge that presents the previous result. The bench issues bursts of consecutive operations with changing opcodes, so every cycle of a burst contains both a capture and a delivery. The scoreboard pops one expected word for each cycle in which `res_valid` is high. A lost, doubled or skewed result then shows up as a mismatch in order. Idle gaps are placed between bursts, and in those gaps the bench checks that the held word is still the last one delivered.

// File: rtl/gf16_pkg.sv
package gf16_pkg;

   localparam int unsigned ELEM_W = 4;
   localparam logic [ELEM_W-1:0] RED_TAIL = 4'b0011; // x^4 = x + 1
   localparam int unsigned TBL_N = 1 << (2 * ELEM_W);

   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_MUL  = 2'b01,
      OP_DBL  = 2'b10,
      OP_PASS = 2'b11
   } gf_op_e;

   // Product by repeated multiply-by-x with conditional reduction
   function automatic logic [ELEM_W-1:0] gf16_mul_fn(input logic [ELEM_W-1:0] a,
                                                     input logic [ELEM_W-1:0] b);
      logic [ELEM_W-1:0] acc;
      logic [ELEM_W-1:0] x;
      acc = '0;
      x   = a;
      for (int i = 0; i < ELEM_W; i++) begin
         if (b[i]) acc = acc ^ x;
         x = {x[ELEM_W-2:0], 1'b0} ^ (x[ELEM_W-1] ? RED_TAIL : '0);
      end
      return acc;
   endfunction

   // Packed table: entry {a,b} sits at bits 4*{a,b}+3 : 4*{a,b}
   function automatic logic [TBL_N*ELEM_W-1:0] gf16_build_table();
      logic [TBL_N*ELEM_W-1:0] t;
      t = '0;
      for (int k = 0; k < TBL_N; k++) begin
         t[k*ELEM_W +: ELEM_W] = gf16_mul_fn(k[7:4], k[3:0]);
      end
      return t;
   endfunction

endpackage

// File: rtl/gf16_mul.sv
module gf16_mul
   import gf16_pkg::*;
#(
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   output logic [ELEM_W-1:0] p
);

   generate
      if (USE_TABLE) begin : g_table
         localparam logic [TBL_N*ELEM_W-1:0] PROD_TBL = gf16_build_table();
         always_comb p = PROD_TBL[{a, b, 2'b00} +: ELEM_W];
      end else begin : g_logic
         always_comb p = gf16_mul_fn(a, b);
      end
   endgenerate

   // Zero annihilates, one is the identity
   always_comb begin
      if (a == '0 || b == '0) a_r9_zero_product: assert (p == '0);
      if (a == 4'd1) a_r9_one_left: assert (p == b);
      if (b == 4'd1) a_r9_one_right: assert (p == a);
   end

endmodule

// File: rtl/gf16_lane.sv
module gf16_lane
   import gf16_pkg::*;
#(
   parameter bit USE_TABLE = 1'b1
) (
   input  gf_op_e            op,
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   output logic [ELEM_W-1:0] r
);

   logic [ELEM_W-1:0] prod;

   gf16_mul #(.USE_TABLE(USE_TABLE)) u_mul (
      .a (a),
      .b (b),
      .p (prod)
   );

   always_comb begin
      unique case (op)
         OP_ADD:  r = a ^ b;
         OP_MUL:  r = prod;
         OP_DBL:  r = a ^ a;   // field sum of a with itself
         OP_PASS: r = a;
         default: r = a;
      endcase
   end

endmodule

// File: rtl/gf16_stage.sv
module gf16_stage #(
   parameter int unsigned W = 256
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic         q_valid,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q       <= '0;
      end else begin
         q_valid <= load;
         if (load) q <= d;
      end
   end

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/gf16_lane_alu.sv
module gf16_lane_alu
   import gf16_pkg::*;
#(
   parameter int unsigned DATA_W    = 256,
   parameter bit          USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              res_valid,
   output logic [DATA_W-1:0] res
);

   localparam int unsigned LANES = DATA_W / ELEM_W;

   generate
      if (DATA_W % ELEM_W != 0 || DATA_W == 0) begin : g_bad_width
         $error("DATA_W must be a nonzero multiple of the lane width");
      end
   endgenerate

   gf_op_e            op_e;
   logic [DATA_W-1:0] lane_out;

   assign op_e = gf_op_e'(op);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         gf16_lane #(.USE_TABLE(USE_TABLE)) u_lane (
            .op (op_e),
            .a  (opa[i*ELEM_W +: ELEM_W]),
            .b  (opb[i*ELEM_W +: ELEM_W]),
            .r  (lane_out[i*ELEM_W +: ELEM_W])
         );
      end
   endgenerate

   gf16_stage #(.W(DATA_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (in_valid),
      .d       (lane_out),
      .q_valid (res_valid),
      .q       (res)
   );

   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);
   a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b00) |=> res == ($past(opa) ^ $past(opb)));
   a_r5_double_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b10) |=> res == '0);
   a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b11) |=> res == $past(opa));

endmodule

// File: tb/sim_gf16_lane_alu.sv
module sim_gf16_lane_alu;

   localparam int unsigned DATA_W   = 256;
   localparam int unsigned LANES    = DATA_W / 4;
   localparam time         CLK_PER  = 10ns;
   localparam int unsigned WD_LIMIT = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [1:0]        op = 2'b00;
   logic [DATA_W-1:0] opa = '0;
   logic [DATA_W-1:0] opb = '0;
   logic              res_valid;
   logic [DATA_W-1:0] res;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   bit seen_any = 1'b0;
   logic [DATA_W-1:0] last_exp = '0;
   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   always #(CLK_PER/2) clk = ~clk;

   gf16_lane_alu #(.DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opa(opa), .opb(opb), .res_valid(res_valid), .res(res)
   );

   // Schoolbook carry-less product, then fold bits 6..4 with 10011
   function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
      logic [6:0] w;
      w = '0;
      for (int i = 0; i < 4; i++) if (b[i]) w = w ^ (7'(a) << i);
      for (int k = 6; k >= 4; k--) if (w[k]) w = w ^ (7'b0010011 << (k - 4));
      return w[3:0];
   endfunction

   function automatic logic [DATA_W-1:0] ref_word(input logic [1:0] o,
                                                  input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < LANES; i++) begin
         case (o)
            2'b00:   r[i*4 +: 4] = a[i*4 +: 4] ^ b[i*4 +: 4];
            2'b01:   r[i*4 +: 4] = ref_mul(a[i*4 +: 4], b[i*4 +: 4]);
            2'b10:   r[i*4 +: 4] = 4'h0;
            default: r[i*4 +: 4] = a[i*4 +: 4];
         endcase
      end
      return r;
   endfunction

   function automatic logic [DATA_W-1:0] rnd_word();
      logic [DATA_W-1:0] w;
      for (int i = 0; i < DATA_W / 32; i++) w[i*32 +: 32] = $urandom;
      return w;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Driver: one operation per call, at the falling edge
   task automatic issue(input logic [1:0] o, input logic [DATA_W-1:0] a,
                        input logic [DATA_W-1:0] b, input string req);
      @(negedge clk);
      in_valid = 1'b1;
      op  = o;
      opa = a;
      opb = b;
      exp_q.push_back(ref_word(o, a, b));
      tag_q.push_back(req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         opa = rnd_word();   // operands change while idle
         opb = rnd_word();
         op  = 2'(i);
      end
   endtask

   // Monitor: pop and compare on result cycles, check hold otherwise
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (res_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected res_valid", res, '0);
            end else begin
               logic [DATA_W-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(res === e, t, res, e);
               last_exp = e;
               seen_any = 1'b1;
            end
         end else if (seen_any) begin
            check(res === last_exp, "R8 hold while idle", res, last_exp);
         end
      end
   end

   initial begin : watchdog
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [DATA_W-1:0] a;
      logic [DATA_W-1:0] b;
      void'($urandom(7));
      #(CLK_PER * 2.3);
      check(res_valid === 1'b0 && res === '0, "R1 reset state", res, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid === 1'b0 && res === '0, "R1 after release", res, '0);

      // R4: 8 x 7 = 13 in lane 0 and lane 63, other lanes zero
      a = '0; b = '0;
      a[3:0] = 4'd8; b[3:0] = 4'd7;
      a[DATA_W-1 -: 4] = 4'd8; b[DATA_W-1 -: 4] = 4'd7;
      issue(2'b01, a, b, "R4 8x7=13 lanes 0 and 63");
      idle(1);
      check(res[3:0] === 4'd13 && res[DATA_W-1 -: 4] === 4'd13,
            "R4 product 13 at edge lanes", res, {4'd13, {(DATA_W-8){1'b0}}, 4'd13});
      check(res[DATA_W-5:4] === '0, "R7 untouched lanes stay zero", res, '0);
      idle(2);

      // R9: zero and one operands in every lane
      a = '0; b = '0;
      for (int i = 0; i < LANES; i++) begin
         a[i*4 +: 4] = 4'(i);
         b[i*4 +: 4] = (i % 2 == 0) ? 4'd0 : 4'd1;
      end
      issue(2'b01, a, b, "R9 product with 0 and 1");
      issue(2'b01, b, a, "R9 product with 0 and 1 swapped");

      // R4: all 256 operand pairs, 64 pairs per word
      for (int w = 0; w < 4; w++) begin
         for (int i = 0; i < LANES; i++) begin
            a[i*4 +: 4] = 4'((w * LANES + i) >> 4);
            b[i*4 +: 4] = 4'(w * LANES + i);
         end
         issue(2'b01, a, b, "R4 exhaustive products");
      end
      idle(3);

      // R7: one live lane, walking
      for (int i = 0; i < LANES; i += 9) begin
         a = '0; b = '0;
         a[i*4 +: 4] = 4'hF; b[i*4 +: 4] = 4'h9;
         issue(2'b01, a, b, "R7 single live lane mul");
         issue(2'b00, a, b, "R7 single live lane add");
      end
      idle(2);

      // Back-to-back bursts mixing all opcodes (R2, R3, R5, R6)
      for (int k = 0; k < 40; k++) begin
         logic [1:0] o;
         o = 2'(k);
         case (o)
            2'b00: issue(o, rnd_word(), rnd_word(), "R3 add burst");
            2'b01: issue(o, rnd_word(), rnd_word(), "R4 mul burst");
            2'b10: issue(o, rnd_word(), rnd_word(), "R5 double burst");
            default: issue(o, rnd_word(), rnd_word(), "R6 pass burst");
         endcase
         if (k % 7 == 6) idle(k % 3 + 1);
      end
      idle(3);
      check(exp_q.size() == 0, "R2 all results delivered", DATA_W'(exp_q.size()), '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule